// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

An eight-channel input bank that cleans up slow external signals and turns them into level interrupts. Each pin is brought into the clock domain by a two-flop synchronizer. A per-channel millisecond filter then passes a change through to the channel's stable value only after the synchronized pin has held its new level for a programmed number of 1 ms ticks. A tick input supplies the millisecond timebase.

A channel reports an event when its stable value equals its programmed active level and software has armed it. The arm is single-shot: capturing an event drops it, so each further event needs a fresh arm. Raw status is masked by a per-channel enable, and one registered interrupt line is the OR of the masked bits. Software reaches everything through a simple word-addressed register port with one-cycle read latency.

Top module: `deb_irq_bank`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: A channel's stable value takes a new synchronized pin level only on the tick on which that level has been seen for L consecutive ticks, where L is the channel's debounce count. If the pin returns to the stable level before then, the count restarts.
- R3: Channel n's debounce count is bits [11:0] of the word at 0x40 + 4*n. Upper write bits are dropped. A count of 0 behaves as 1.
- R4: A read of 0x00 returns each channel's stable value ANDed with the data enable bits held at 0x04.
- R5: A channel whose arm bit (0x28) is 1 and whose stable value equals its polarity bit (0x14; 1 = active high, 0 = active low) sets its raw status bit (0x1C) on the next clock edge. On the same edge its arm bit returns to 0.
- R6: A channel whose arm bit is 0 never sets its raw status bit.
- R7: Writing 0x24 clears the raw bits written as 1 and leaves the bits written as 0 untouched. Reads of 0x24 return 0.
- R8: A read of 0x20 returns the raw status ANDed with the interrupt enable bits (0x18).
- R9: `irq` is 1 exactly when the masked status of the previous cycle was non-zero.
- R10: Read data appears one cycle after the address. Addresses outside the map, including debounce words past the last channel, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| pin_in | input | NCH | Asynchronous external inputs |
| reg_addr | input | 8 | Byte address of the register word |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
A pin change reaches the filter after two edges. The stable value moves on the L-th tick edge after that. Raw status follows one edge later, and `irq` one edge after that. Register writes act on their own edge, and read data is valid one edge after the address. The bench waits three cycles after each pin change before it counts ticks. It samples stable data after L-1 ticks and again after L ticks. It waits at least two edges after any write before it reads status or `irq`, and it samples only on falling edges.

// File: rtl/deb_irq_pkg.sv
package deb_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  // register word addresses
  localparam logic [ADDR_W-1:0] A_STABLE = 8'h00;
  localparam logic [ADDR_W-1:0] A_DMASK  = 8'h04;
  localparam logic [ADDR_W-1:0] A_POL    = 8'h14;
  localparam logic [ADDR_W-1:0] A_IEN    = 8'h18;
  localparam logic [ADDR_W-1:0] A_RAW    = 8'h1C;
  localparam logic [ADDR_W-1:0] A_MASKED = 8'h20;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 8'h24;
  localparam logic [ADDR_W-1:0] A_ARM    = 8'h28;
  localparam logic [ADDR_W-1:0] A_DBNC   = 8'h40;
endpackage

// File: rtl/deb_sync2.sv
module deb_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/deb_chan_filter.sv
module deb_chan_filter #(
  parameter int DBW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           din,
  input  logic [DBW-1:0] limit,
  output logic           stable
);
  logic [DBW-1:0] cnt;
  logic [DBW-1:0] lim_eff;
  logic [DBW-1:0] cnt_nx;

  // a zero count behaves as one tick
  assign lim_eff = (limit == '0) ? DBW'(1) : limit;
  assign cnt_nx  = cnt + DBW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      stable <= 1'b0;
    end else if (din == stable) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt_nx >= lim_eff) begin
        stable <= din;
        cnt    <= '0;
      end else begin
        cnt <= cnt_nx;
      end
    end
  end

  // R2: stable only moves on a tick edge
  a_r2_move_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(stable) |-> $past(tick));
  // R2: stable only moves to the synchronized level
  a_r2_takes_input: assert property (@(posedge clk) disable iff (rst)
    !$stable(stable) |-> (stable == $past(din)));
endmodule

// File: rtl/deb_irq_bank.sv
module deb_irq_bank
  import deb_irq_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DBW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1ms,
  input  logic [NCH-1:0]    pin_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [ADDR_W-1:0] DBNC_END = A_DBNC + ADDR_W'(4 * NCH);

  logic [NCH-1:0] pin_s, stable;
  logic [NCH-1:0] dmask, pol, ien, raw, arm;
  logic [NCH-1:0] match, capture, clr_v;
  logic [DBW-1:0] dbnc [NCH];
  logic           dbnc_hit;
  logic [ADDR_W-1:0] dbnc_off;
  logic [IW-1:0]  dbnc_idx;
  logic           unused_bits;

  assign unused_bits = ^{reg_wdata[DATA_W-1:(DBW > NCH ? DBW : NCH)]};

  deb_sync2 #(.W(NCH)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  assign dbnc_off = reg_addr - A_DBNC;
  assign dbnc_idx = dbnc_off[IW+1:2];
  assign dbnc_hit = (reg_addr[1:0] == 2'b00) && (reg_addr >= A_DBNC) &&
                    (reg_addr < DBNC_END);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    deb_chan_filter #(.DBW(DBW)) u_filt (
      .clk(clk), .rst(rst), .tick(tick_1ms), .din(pin_s[c]),
      .limit(dbnc[c]), .stable(stable[c])
    );
    always_ff @(posedge clk) begin
      if (rst)
        dbnc[c] <= '0;
      else if (reg_we && dbnc_hit && (dbnc_idx == IW'(c)))
        dbnc[c] <= reg_wdata[DBW-1:0];
    end
  end

  assign match   = ~(stable ^ pol);
  assign capture = arm & match;
  assign clr_v   = (reg_we && reg_addr == A_CLEAR) ? reg_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dmask <= '0;
      pol   <= '0;
      ien   <= '0;
      raw   <= '0;
      arm   <= '0;
      irq   <= 1'b0;
    end else begin
      if (reg_we && reg_addr == A_DMASK) dmask <= reg_wdata[NCH-1:0];
      if (reg_we && reg_addr == A_POL)   pol   <= reg_wdata[NCH-1:0];
      if (reg_we && reg_addr == A_IEN)   ien   <= reg_wdata[NCH-1:0];
      if (reg_we && reg_addr == A_ARM)   arm   <= reg_wdata[NCH-1:0];
      else                               arm   <= arm & ~capture;
      // a fresh capture wins over a clear in the same cycle
      raw <= (raw & ~clr_v) | capture;
      irq <= |(raw & ien);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (dbnc_hit)
        reg_rdata <= DATA_W'(dbnc[dbnc_idx]);
      else
        case (reg_addr)
          A_STABLE: reg_rdata <= DATA_W'(stable & dmask);
          A_DMASK:  reg_rdata <= DATA_W'(dmask);
          A_POL:    reg_rdata <= DATA_W'(pol);
          A_IEN:    reg_rdata <= DATA_W'(ien);
          A_RAW:    reg_rdata <= DATA_W'(raw);
          A_MASKED: reg_rdata <= DATA_W'(raw & ien);
          A_ARM:    reg_rdata <= DATA_W'(arm);
          default:  reg_rdata <= '0;
        endcase
    end
  end

  // R5: an armed match lands in raw status on the next edge
  a_r5_capture_sets_raw: assert property (@(posedge clk) disable iff (rst)
    (capture != '0) |=> ((raw & $past(capture)) == $past(capture)));
  // R6: a raw bit can only rise if the channel was armed
  a_r6_raw_needs_arm: assert property (@(posedge clk) disable iff (rst)
    ((raw & ~$past(raw) & ~$past(arm)) == '0));
  // R7: a cleared bit without a concurrent capture is gone next cycle
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    ((clr_v & ~capture) != '0) |=> ((raw & $past(clr_v & ~capture)) == '0));
  // R9: irq only rises after masked status was pending
  a_r9_irq_source: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((raw & ien) != '0));
endmodule

// File: tb/deb_irq_bank_bench.sv
module deb_irq_bank_bench;
  localparam int NCH = 8;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1ms = 1'b0;
  logic [NCH-1:0] pin_in = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  deb_irq_bank #(.NCH(NCH), .DBW(12)) u_deb_irq_bank (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .pin_in(pin_in),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_masked(logic [31:0] r, logic [31:0] e);
    return r & e;
  endfunction

  function automatic int eff_len(int l);
    return (l == 0) ? 1 : l;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1ms = 1'b1;
      @(negedge clk); tick_1ms = 1'b0;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, r, e;
    logic [NCH-1:0] exp_st;
    void'($urandom(32'h0000_5EED));
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 0);
    rd(8'h00, v); chk("R1 stable", v, 0);
    rd(8'h14, v); chk("R1 pol", v, 0);
    rd(8'h1C, v); chk("R1 raw", v, 0);
    rd(8'h28, v); chk("R1 arm", v, 0);
    rd(8'h40, v); chk("R1 dbnc0", v, 0);

    // R3: debounce word width
    wr(8'h40, 32'd3);
    rd(8'h40, v); chk("R3 dbnc0", v, 3);
    wr(8'h44, 32'hFFFF_F123);
    rd(8'h44, v); chk("R3 dbnc1 field", v, 32'h123);

    // R2: debounce channel 0, L = 3
    wr(8'h04, 32'hFF);
    pin_in[0] = 1'b1; idle(3);
    ticks(2);
    rd(8'h00, v); chk("R2 before L ticks", v, 0);
    ticks(1);
    rd(8'h00, v); chk("R2 after L ticks", v, 1);
    // R2: glitch shorter than L restarts the count
    pin_in[0] = 1'b0; idle(3); ticks(2);
    pin_in[0] = 1'b1; idle(3); ticks(3);
    rd(8'h00, v); chk("R2 glitch rejected", v, 1);

    // R3: zero count acts as one tick
    wr(8'h48, 32'd0);
    pin_in[2] = 1'b1; idle(3); ticks(1);
    rd(8'h00, v); chk("R3 zero count", v, 32'h05);

    // R4: data enable gates readback
    wr(8'h04, 32'h01);
    rd(8'h00, v); chk("R4 data enable", v, 32'h01);
    wr(8'h04, 32'hFF);

    // R6: matching but unarmed channels stay quiet
    wr(8'h14, 32'h01);
    wr(8'h18, 32'h01);
    idle(3);
    rd(8'h1C, v); chk("R6 unarmed raw", v, 0);
    chk("R6 irq", {31'b0, irq}, 0);

    // R5: arm channel 0
    wr(8'h28, 32'h01);
    idle(3);
    rd(8'h1C, v); chk("R5 raw set", v, 32'h01);
    rd(8'h28, v); chk("R5 arm auto clear", v, 0);
    rd(8'h20, v); chk("R8 masked", v, exp_masked(32'h01, 32'h01));
    chk("R9 irq on", {31'b0, irq}, 1);

    // R7: clear
    wr(8'h24, 32'h00); idle(2);
    rd(8'h1C, v); chk("R7 zero write no effect", v, 32'h01);
    wr(8'h24, 32'h01); idle(2);
    rd(8'h1C, v); chk("R7 cleared", v, 0);
    chk("R9 irq off", {31'b0, irq}, 0);
    rd(8'h24, v); chk("R7 clear reads 0", v, 0);

    // R8/R9: active-low capture on channel 3, masked off
    wr(8'h28, 32'h08); idle(3);
    rd(8'h1C, v); chk("R5 active low", v, 32'h08);
    rd(8'h20, v); chk("R8 masked off", v, 0);
    chk("R9 masked irq", {31'b0, irq}, 0);
    wr(8'h18, 32'h09); idle(1);
    chk("R9 enable raises irq", {31'b0, irq}, 1);
    wr(8'h24, 32'h08); idle(2);
    chk("R9 irq drops", {31'b0, irq}, 0);

    // R10: unmapped reads
    rd(8'h08, v); chk("R10 unmapped", v, 0);
    rd(8'h60, v); chk("R10 past last word", v, 0);

    // random debounce on channels 4..7
    exp_st = 8'h05;
    for (int it = 0; it < 20; it++) begin
      int ch, l;
      ch = 4 + int'($urandom % 4);
      l  = int'($urandom % 6);
      wr(8'h40 + 8'(4 * ch), 32'(l));
      pin_in[ch] = ~exp_st[ch];
      idle(3);
      ticks(eff_len(l) - 1);
      rd(8'h00, v); chk("R2 random hold", v, 32'(exp_st));
      ticks(1);
      exp_st[ch] = ~exp_st[ch];
      rd(8'h00, v); chk("R2 random update", v, 32'(exp_st));
      e = 32'($urandom % 256);
      wr(8'h18, e);
      rd(8'h1C, r);
      rd(8'h20, v); chk("R8 random mask", v, exp_masked(r, e));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule